// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and a 16-bit asynchronous static RAM with per-byte enables. It takes one single-word read or write request at a time and turns it into a sequence of chip-select, output-enable, write-enable and byte-lane strobes. The length of each strobe phase is a whole number of clock cycles. These cycle counts are computed at elaboration from the memory's nanosecond timing parameters and a clock-period parameter, and the results are rounded up.

The host side is a valid/ready request port. A request is taken on a clock edge at which both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle, so the host applies back-pressure by keeping its request and fields stable until it sees the handshake. The response side has no back-pressure. `rsp_valid` pulses for exactly one cycle at the end of each access, and the host must take `rsp_rdata` in that cycle. `rsp_rdata` then holds the word from the last read until the next read completes. `busy` is high for the whole access.

Every access runs through the same phases: a setup phase with the address, chip select and byte enables applied; a strobe phase in which output enable (read) or write enable (write) is low; a recovery phase; and a one-cycle completion. The address and write data are registered at acceptance and stay steady through the whole access.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_be_n` is 2'b11 and `mem_dq_oe` is low. At the same time `req_ready` is high and `busy` and `rsp_valid` are low.
- R2: A request is accepted only on an edge where `req_ready` is high, and `req_ready` is high exactly when `busy` is low. A `req_valid` pulse while busy is ignored and leaves memory contents unchanged.
- R3: With default timing (5 ns clock, 70 ns address access, 40 ns output-enable access, 70 ns read cycle), a read timeline after the accepting edge is fixed:
  - cycle 1 is setup (chip select low, output enable high);
  - cycles 2 to 14 have output enable low;
  - cycle 15 is recovery;
  - cycle 16 has `rsp_valid` high.
- R4: Read data is sampled from `mem_dq_in` on the edge that ends the last output-enable-low cycle. By then the address has been applied for at least the address access time. The sampled word appears on `rsp_rdata` with `rsp_valid`.
- R5: With default timing (50 ns pulse width, 60 ns chip/address/byte-to-write-end, 70 ns write cycle), a write timeline after the accepting edge is fixed:
  - cycle 1 is setup;
  - cycles 2 to 12 have write enable low;
  - cycles 13 and 14 are recovery;
  - cycle 15 has `rsp_valid` high.
- R6: Request mask bit 0 selects the low data byte, which the lane `mem_be_n[0]` (active low) drives. Mask bit 1 selects the high data byte, which `mem_be_n[1]` drives. During cycles 1 to len-1 of an access, `mem_be_n` equals the inverted mask, and outside an access it is 2'b11. Bytes not selected in a write keep their old content.
- R7: `mem_dq_oe` is high only while write enable is low and output enable is high. In the cycle before output enable goes low, `mem_dq_oe` is low.
- R8: `mem_addr` equals the accepted address from the setup cycle through recovery, and it never changes while chip select and write enable are both low. `mem_dq_out` equals the accepted write data over the same span.
- R9: `busy` is high from the cycle after acceptance through the `rsp_valid` cycle: 16 cycles for a read and 15 for a write. `rsp_valid` is never high for two cycles in a row.
- R10: A request kept valid while the controller is busy is accepted on the first edge after the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read word |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte lane enables, active low |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data read from memory |

## Verification
The assertions check properties that hold on every cycle:
- the data drive enable only inside the write pulse, with a free cycle before output enable falls;
- a steady address while chip select and write enable overlap;
- write and read pulses no shorter than the derived minimum;
- byte lanes only under chip select;
- the `req_ready`/`busy` exclusion;
- single-cycle completion pulses.

Only the bench scenarios show the exact cycle counts of each phase. They also show that read data is taken at a moment when a memory model with a 70 ns access time is already driving valid data, and that partial-byte writes leave the other byte intact. They show that a request pulsed during busy is dropped, and that back-to-back requests chain with one idle cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } sram_phase_e;

  // whole clock cycles covering a time in ns (rounded up)
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctl_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sram_phase_e      phase_d,
  input  logic             wr_d,
  input  logic [BYTES-1:0] mask_d,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [BYTES-1:0] be_n,
  output logic             dq_oe
);
  logic active_d;
  logic pulse_d;

  assign active_d = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                    (phase_d == PH_HOLD);
  assign pulse_d  = (phase_d == PH_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= !active_d;
      oe_n  <= !(pulse_d && !wr_d);
      we_n  <= !(pulse_d && wr_d);
      dq_oe <= pulse_d && wr_d;
    end
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) be_n[i] <= 1'b1;
      else        be_n[i] <= !(active_d && mask_d[i]);
    end
  end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 40,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_CW_NS = 60,
  parameter int T_AW_NS = 60,
  parameter int T_BW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int SETUP_CYC = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W/8-1:0]    mem_be_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);
  localparam int BYTES = DATA_W / 8;

  // read: address applied in setup, output enable low until access time met
  localparam int RD_STB_CYC = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS) - SETUP_CYC,
                                        ns_to_cyc(T_OE_NS, CLK_NS)), 1);
  localparam int RD_REC_CYC = imax(ns_to_cyc(T_RC_NS, CLK_NS) - SETUP_CYC - RD_STB_CYC, 1);
  // write: pulse long enough for pulse width and every "to write end" limit
  localparam int WR_STB_CYC = imax(imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                             ns_to_cyc(T_CW_NS, CLK_NS) - SETUP_CYC),
                                        imax(ns_to_cyc(T_AW_NS, CLK_NS) - SETUP_CYC,
                                             ns_to_cyc(T_BW_NS, CLK_NS) - SETUP_CYC)),
                                   imax(ns_to_cyc(T_DW_NS, CLK_NS), 1));
  localparam int WR_REC_CYC = imax(ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - WR_STB_CYC, 1);
  localparam int MAX_CYC    = imax(imax(RD_STB_CYC, WR_STB_CYC),
                                   imax(imax(RD_REC_CYC, WR_REC_CYC), SETUP_CYC));
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  sram_phase_e          phase_q, phase_d;
  logic                 wr_q, wr_d;
  logic [BYTES-1:0]     mask_q, mask_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 accept;
  logic                 expired;
  logic [CNT_W-1:0]     load_val;

  assign accept = (phase_q == PH_IDLE) && req_valid;
  assign wr_d   = accept ? req_write : wr_q;
  assign mask_d = accept ? req_mask  : mask_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (req_valid) phase_d = PH_SETUP;
      PH_SETUP:  if (expired)   phase_d = PH_STROBE;
      PH_STROBE: if (expired)   phase_d = PH_HOLD;
      PH_HOLD:   if (expired)   phase_d = PH_DONE;
      PH_DONE:                  phase_d = PH_IDLE;
      default:                  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_SETUP:  load_val = CNT_W'(SETUP_CYC - 1);
      PH_STROBE: load_val = wr_d ? CNT_W'(WR_STB_CYC - 1) : CNT_W'(RD_STB_CYC - 1);
      PH_HOLD:   load_val = wr_d ? CNT_W'(WR_REC_CYC - 1) : CNT_W'(RD_REC_CYC - 1);
      default:   load_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_d != phase_q),
    .load_val (load_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      mask_q  <= mask_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (phase_q == PH_STROBE && expired && !wr_q)
        rdata_q <= mem_dq_in;
    end
  end

  sram_strobe_gen #(.BYTES(BYTES)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_d (phase_d),
    .wr_d    (wr_d),
    .mask_d  (mask_d),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .be_n    (mem_be_n),
    .dq_oe   (mem_dq_oe)
  );

  assign req_ready  = (phase_q == PH_IDLE);
  assign busy       = (phase_q != PH_IDLE);
  assign rsp_valid  = (phase_q == PH_DONE);
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W     = 17,
  parameter int BYTES      = 2,
  parameter int MIN_WE_CYC = 1,
  parameter int MIN_OE_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [BYTES-1:0]  mem_be_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [15:0] we_low_cnt;
  logic [15:0] oe_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
      oe_low_cnt <= mem_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
    end
  end

  // R2
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R9
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  // R7
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_dq_oe));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n) |-> $stable(mem_addr));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= 16'(MIN_WE_CYC)));

  // R3
  oe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_cnt >= 16'(MIN_OE_CYC)));

  // R6
  lane_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n != {BYTES{1'b1}}) |-> !mem_ce_n);
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .BYTES      (BYTES),
  .MIN_WE_CYC (WR_STB_CYC),
  .MIN_OE_CYC (RD_STB_CYC)
) u_chk (.*);

// File: tb/sram_async_ctl_test.sv
module sram_async_ctl_test;
  // expected timelines, worked out from the requirements at a 5 ns clock
  localparam int RD_LEN   = 16;  // R3: setup 1, oe low 2..14, recovery 15, done 16
  localparam int WR_LEN   = 15;  // R5: setup 1, we low 2..12, recovery 13..14, done 15
  localparam int OE_FIRST = 2, OE_LAST = 14;
  localparam int WE_FIRST = 2, WE_LAST = 12;
  localparam int AA_VALID = 12;  // model stable count at which 70 ns is reached by next edge

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, busy, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sram_async_ctl uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- memory model: 70 ns access, byte lanes ----------------
  logic [15:0] mm [256];
  logic [15:0] shadow [256];
  int          stab = 0;
  logic [16:0] last_addr = '0;
  logic        prev_ce_low = 1'b0;
  logic        cap_v = 1'b0;
  logic [16:0] cap_a;
  logic [15:0] cap_d;
  logic [1:0]  cap_b;

  initial for (int i = 0; i < 256; i++) begin mm[i] = 16'h0; shadow[i] = 16'h0; end

  always @(posedge clk) begin
    if (mem_ce_n || !prev_ce_low || mem_addr != last_addr) stab <= 0;
    else stab <= stab + 1;
    last_addr   <= mem_addr;
    prev_ce_low <= !mem_ce_n;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      cap_v <= 1'b1; cap_a <= mem_addr; cap_d <= mem_dq_out; cap_b <= mem_be_n;
    end else if (cap_v && mem_we_n) begin
      cap_v <= 1'b0;
      if (!cap_b[0]) mm[cap_a[7:0]][7:0]  <= cap_d[7:0];
      if (!cap_b[1]) mm[cap_a[7:0]][15:8] <= cap_d[15:8];
    end
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && stab >= AA_VALID) ? mm[mem_addr[7:0]] : 16'hDEAD;

  // ---------------- cycle-by-cycle reference ----------------
  int          k = 0;
  bit          m_wr = 1'b0;
  logic [16:0] m_addr = '0;
  logic [15:0] m_wd = '0;
  logic [1:0]  m_mask = '0;

  always @(negedge clk) if (rst_n) begin
    int len;
    logic e_ce, e_oe, e_we, e_dq, e_rsp;
    logic [1:0] e_be;
    len   = m_wr ? WR_LEN : RD_LEN;
    e_ce  = !(k >= 1 && k <= len - 1);
    e_oe  = !(!m_wr && k >= OE_FIRST && k <= OE_LAST);
    e_we  = !(m_wr && k >= WE_FIRST && k <= WE_LAST);
    e_dq  = m_wr && k >= WE_FIRST && k <= WE_LAST;
    e_rsp = (k == len);
    e_be  = e_ce ? 2'b11 : ~m_mask;
    check(req_ready === (k == 0), "R2", "req_ready", 32'(req_ready), 32'(k == 0));
    check(busy === (k != 0), "R9", "busy", 32'(busy), 32'(k != 0));
    check(rsp_valid === e_rsp, "R9", "rsp_valid", 32'(rsp_valid), 32'(e_rsp));
    check(mem_ce_n === e_ce, m_wr ? "R5" : "R3", "ce_n", 32'(mem_ce_n), 32'(e_ce));
    check(mem_oe_n === e_oe, "R3", "oe_n", 32'(mem_oe_n), 32'(e_oe));
    check(mem_we_n === e_we, "R5", "we_n", 32'(mem_we_n), 32'(e_we));
    check(mem_dq_oe === e_dq, "R7", "dq_oe", 32'(mem_dq_oe), 32'(e_dq));
    check(mem_be_n === e_be, "R6", "be_n", 32'(mem_be_n), 32'(e_be));
    if (k >= 1 && k < len) begin
      check(mem_addr === m_addr, "R8", "mem_addr", 32'(mem_addr), 32'(m_addr));
      if (m_wr) check(mem_dq_out === m_wd, "R8", "dq_out", 32'(mem_dq_out), 32'(m_wd));
    end
    if (e_rsp && !m_wr)
      check(rsp_rdata === shadow[m_addr[7:0]], "R4", "rsp_rdata",
            32'(rsp_rdata), 32'(shadow[m_addr[7:0]]));
    if (k == 0) begin
      if (req_valid) begin
        k = 1; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_mask = req_mask;
        if (req_write) begin
          if (req_mask[0]) shadow[req_addr[7:0]][7:0]  = req_wdata[7:0];
          if (req_mask[1]) shadow[req_addr[7:0]][15:8] = req_wdata[15:8];
        end
      end
    end else if (k == len) k = 0;
    else k = k + 1;
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1", "strobes",
          32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'h7);
    check(mem_be_n === 2'b11, "R1", "be_n", 32'(mem_be_n), 32'h3);
    check(mem_dq_oe === 1'b0 && rsp_valid === 1'b0 && busy === 1'b0, "R1", "dq_oe/rsp/busy",
          32'({mem_dq_oe, rsp_valid, busy}), 32'h0);
    check(req_ready === 1'b1, "R1", "req_ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 R4: full-word writes and reads
    issue(1'b1, 17'h00010, 16'h1234, 2'b11);
    issue(1'b0, 17'h00010, 16'h0, 2'b11);
    issue(1'b1, 17'h1FFFF, 16'hA5C3, 2'b11);
    issue(1'b0, 17'h1FFFF, 16'h0, 2'b11);
    // R6: low byte only, high byte only, no byte
    issue(1'b1, 17'h00010, 16'hFFEE, 2'b01);
    issue(1'b0, 17'h00010, 16'h0, 2'b11);
    issue(1'b1, 17'h00010, 16'h77FF, 2'b10);
    issue(1'b0, 17'h00010, 16'h0, 2'b01);
    issue(1'b1, 17'h1FFFF, 16'h0000, 2'b00);
    issue(1'b0, 17'h1FFFF, 16'h0, 2'b10);
    // R10: back-to-back read after read at the same address
    issue(1'b0, 17'h1FFFF, 16'h0, 2'b11);
    issue(1'b0, 17'h1FFFF, 16'h0, 2'b11);
    drain();

    // R2: a one-cycle request pulse while busy is dropped
    issue(1'b1, 17'h00033, 16'h5151, 2'b11);
    drain();
    issue(1'b0, 17'h00040, 16'h0, 2'b11);
    repeat (4) @(posedge clk);
    #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00033; req_wdata = 16'hBEEF; req_mask = 2'b11;
    @(posedge clk); #1;
    req_valid = 1'b0;
    drain();
    issue(1'b0, 17'h00033, 16'h0, 2'b11);
    drain();
    // R2: result of the dropped write seen at the port
    check(rsp_rdata === 16'h5151, "R2", "ignored write", 32'(rsp_rdata), 32'h5151);
    // R6: high byte kept after low-byte write, then low byte kept after high-byte write
    issue(1'b0, 17'h00010, 16'h0, 2'b11);
    drain();
    check(rsp_rdata === 16'h77EE, "R6", "merged word", 32'(rsp_rdata), 32'h77EE);

    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule